// File: doc/BRIEF.md
# Serial CRC-8 Accumulator for Unaligned Frames

This block keeps a running 8-bit cyclic redundancy remainder over a stream of single bits, one bit per clock, most significant bit first. The stream may be any length, including lengths that are not whole bytes. This suits radio link frames whose address and control fields end at arbitrary bit positions. The surrounding logic decides which bits are covered. It asserts a strobe for each covered bit and reads the remainder whenever it needs it.

The generator is x^8 + x^2 + x + 1, written as 0x07 with the x^8 term implied. The remainder starts from all ones. The output is the register itself: it is not inverted and not bit-reversed. On the receive side, the frame's CRC field is fed through the same path after the data. A zero-remainder flag then goes high when the frame is intact.

Top module: `crc8_serial`

## Requirements
- R1: A synchronous reset held high at a rising edge sets `crc_out` to 0xFF after that edge, regardless of the other inputs.
- R2: `clear` high at a rising edge (reset low) sets `crc_out` to 0xFF after that edge.
- R3: When `clear` and `bit_valid` are both high at the same edge, the bit is discarded and `crc_out` becomes 0xFF.
- R4: With `bit_valid` high and `clear` low, let f = `crc_out[7]` XOR `bit_in`. After the edge, `crc_out` becomes {`crc_out[6:0]`,0}, XORed with 0x07 when f is 1.
- R5: With `bit_valid` and `clear` both low, `crc_out` holds its value across the edge.
- R6: Any bit count from 1 upward is accepted with no byte alignment. The 57 bits 000000000000000100010000000000000100000100000100000111111, fed left to right after a clear, leave `crc_out` at 0x76.
- R7: `crc_zero` is high exactly when `crc_out` is 0x00. After a frame, feeding that frame's 8-bit remainder MSB first drives `crc_out` to 0x00, which raises `crc_zero`.
- R8: `crc_out` is the raw register, with no output inversion and no bit reversal. It changes only at a rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| clear | input | 1 | Reload the seed value; overrides a same-cycle bit |
| bit_valid | input | 1 | Qualifies `bit_in` as a covered bit |
| bit_in | input | 1 | Serial data bit, MSB first |
| crc_out | output | 8 | Current remainder |
| crc_zero | output | 1 | High when the remainder is zero |

## Verification
The fixed 57-bit frame pins the seed, the polynomial, the feedback tap and the bit order at the same time. A zero seed, a reflected shift or a wrong tap each gives a value other than 0x76. Random frame lengths from 1 to 300 bits include many lengths that are not whole bytes, so a design that only updates on byte boundaries drifts off the model. Each frame is followed by its own remainder, so a design with a final inversion or with the flag tied to the wrong state never shows zero. Idle gaps inside frames catch a register that advances without the strobe. A bit that arrives together with `clear` catches a design that gives the bit priority.

// File: rtl/crc8s_pkg.sv
package crc8s_pkg;
  localparam int unsigned CRC_W = 8;
  localparam logic [CRC_W-1:0] CRC_POLY = 8'h07;
  localparam logic [CRC_W-1:0] CRC_SEED = 8'hFF;

  // One serial update, MSB-first, generator taps in poly.
  function automatic logic [CRC_W-1:0] crc_advance(
    input logic [CRC_W-1:0] cur,
    input logic             din,
    input logic [CRC_W-1:0] poly
  );
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/crc8s_step.sv
module crc8s_step #(
  parameter int unsigned     W    = crc8s_pkg::CRC_W,
  parameter logic [W-1:0]    POLY = crc8s_pkg::CRC_POLY
) (
  input  logic [W-1:0] cur,
  input  logic         din,
  output logic         fb,
  output logic [W-1:0] nxt
);
  assign fb = cur[W-1] ^ din;

  // Shift left by one; each tap position folds the feedback bit in.
  for (genvar i = 0; i < W; i++) begin : g_bit
    if (i == 0) begin : g_lsb
      assign nxt[i] = POLY[i] & fb;
    end else begin : g_up
      assign nxt[i] = cur[i-1] ^ (POLY[i] & fb);
    end
  end
endmodule

// File: rtl/crc8s_state.sv
module crc8s_state #(
  parameter int unsigned  W    = crc8s_pkg::CRC_W,
  parameter logic [W-1:0] SEED = crc8s_pkg::CRC_SEED
) (
  input  logic         clk,
  input  logic         load_seed,
  input  logic         adv,
  input  logic [W-1:0] nxt,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (load_seed)  q <= SEED;
    else if (adv)   q <= nxt;
  end
endmodule

// File: rtl/crc8s_zero.sv
module crc8s_zero #(
  parameter int unsigned W = crc8s_pkg::CRC_W
) (
  input  logic [W-1:0] val,
  output logic         is_zero
);
  assign is_zero = ~|val;
endmodule

// File: rtl/crc8_serial.sv
module crc8_serial #(
  parameter int unsigned  W    = crc8s_pkg::CRC_W,
  parameter logic [W-1:0] POLY = crc8s_pkg::CRC_POLY,
  parameter logic [W-1:0] SEED = crc8s_pkg::CRC_SEED
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear,
  input  logic         bit_valid,
  input  logic         bit_in,
  output logic [W-1:0] crc_out,
  output logic         crc_zero
);
  // Named internal events
  logic         load_seed;
  logic         step_en;
  logic         fb_bit;
  logic [W-1:0] rem_q;
  logic [W-1:0] rem_nxt;

  assign load_seed = rst | clear;
  assign step_en   = bit_valid & ~load_seed;

  crc8s_step #(.W(W), .POLY(POLY)) u_step (
    .cur (rem_q),
    .din (bit_in),
    .fb  (fb_bit),
    .nxt (rem_nxt)
  );

  crc8s_state #(.W(W), .SEED(SEED)) u_state (
    .clk       (clk),
    .load_seed (load_seed),
    .adv       (step_en),
    .nxt       (rem_nxt),
    .q         (rem_q)
  );

  crc8s_zero #(.W(W)) u_zero (
    .val     (rem_q),
    .is_zero (crc_zero)
  );

  assign crc_out = rem_q;
endmodule

// File: rtl/crc8_serial_chk.sv
module crc8_serial_chk #(
  parameter int unsigned  W    = 8,
  parameter logic [W-1:0] POLY = 8'h07,
  parameter logic [W-1:0] SEED = 8'hFF
) (
  input logic         clk,
  input logic         rst,
  input logic         clear,
  input logic         bit_valid,
  input logic         bit_in,
  input logic [W-1:0] crc_out,
  input logic         crc_zero,
  input logic         step_en,
  input logic         fb_bit
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  // R1: reset seeds the register
  always_ff @(posedge clk) begin
    if (rst_q === 1'b1) begin
      a_r1_reset_seed: assert (crc_out == SEED);
    end
  end

  a_r2_clear_seed: assert property (@(posedge clk) disable iff (rst)
    clear |=> crc_out == SEED);

  a_r3_clear_wins: assert property (@(posedge clk) disable iff (rst)
    (clear && bit_valid) |-> !step_en);

  a_r4_shift_only: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !clear && !(crc_out[W-1] ^ bit_in)) |=>
      crc_out == {$past(crc_out[W-2:0]), 1'b0});

  a_r4_shift_poly: assert property (@(posedge clk) disable iff (rst)
    (bit_valid && !clear && (crc_out[W-1] ^ bit_in)) |=>
      crc_out == ({$past(crc_out[W-2:0]), 1'b0} ^ POLY));

  a_r4_fb_tap: assert property (@(posedge clk) disable iff (rst)
    step_en |-> fb_bit == (crc_out[W-1] ^ bit_in));

  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (!bit_valid && !clear) |=> $stable(crc_out));

  a_r7_flag_set: assert property (@(posedge clk) disable iff (rst)
    crc_zero |-> crc_out == '0);

  a_r7_flag_clr: assert property (@(posedge clk) disable iff (rst)
    !crc_zero |-> crc_out != '0);
endmodule

bind crc8_serial crc8_serial_chk #(.W(W), .POLY(POLY), .SEED(SEED)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .clear     (clear),
  .bit_valid (bit_valid),
  .bit_in    (bit_in),
  .crc_out   (crc_out),
  .crc_zero  (crc_zero),
  .step_en   (step_en),
  .fb_bit    (fb_bit)
);

// File: tb/sim_crc8_serial.sv
module sim_crc8_serial;
  localparam time PERIOD = 10ns;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       clear = 1'b0;
  logic       bit_valid = 1'b0;
  logic       bit_in = 1'b0;
  logic [7:0] crc_out;
  logic       crc_zero;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  typedef struct {
    logic [7:0] crc;
    string      tag;
  } exp_t;
  exp_t exp_q[$];

  logic [7:0] model = 8'hFF;

  always #(PERIOD/2) clk = ~clk;

  crc8_serial u0 (
    .clk(clk), .rst(rst), .clear(clear), .bit_valid(bit_valid),
    .bit_in(bit_in), .crc_out(crc_out), .crc_zero(crc_zero)
  );

  // Model restated as polynomial long division: append bit, reduce by 0x107.
  function automatic logic [7:0] ref_step(logic [7:0] c, logic b);
    logic [8:0] t;
    t = {c, 1'b0} ^ {b, 8'h00};
    if (t[8]) t = t ^ 9'h107;
    return t[7:0];
  endfunction

  task automatic check(string tag, logic [7:0] act, logic [7:0] expv);
    checks++;
    if (act !== expv) begin
      failures++;
      $display("FAIL %s actual=%02h expected=%02h", tag, act, expv);
    end
  endtask

  // Driver: one cycle of stimulus, push the expected post-edge value.
  task automatic drive(logic r, logic c, logic v, logic b, string tag);
    exp_t e;
    @(negedge clk);
    rst = r; clear = c; bit_valid = v; bit_in = b;
    if (r || c) model = 8'hFF;
    else if (v) model = ref_step(model, b);
    e.crc = model; e.tag = tag;
    exp_q.push_back(e);
  endtask

  // Monitor: compare after each edge.
  always @(posedge clk) begin
    #1;
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      check(e.tag, crc_out, e.crc);
      check({e.tag, " R7 flag"}, {7'b0, crc_zero}, {7'b0, e.crc == 8'h00});
    end
  end

  localparam string FRAME57 =
    "000000000000000100010000000000000100000100000100000111111";

  initial begin
    logic [7:0] fin;
    void'($urandom(32'h5A17));
    drive(1, 0, 1, 1, "R1 reset");
    drive(1, 1, 1, 0, "R1 reset");
    drive(0, 0, 0, 0, "R5 idle after reset");
    drive(0, 0, 0, 1, "R5 idle");

    // R6 fixed frame
    drive(0, 1, 0, 0, "R2 clear");
    for (int i = 0; i < FRAME57.len(); i++)
      drive(0, 0, 1, FRAME57[i] == "1", "R4 R6 frame57");
    drive(0, 0, 0, 0, "R5 hold");
    @(negedge clk);
    check("R6 R8 frame57 value", crc_out, 8'h76);
    fin = crc_out;
    for (int i = 7; i >= 0; i--)
      drive(0, 0, 1, fin[i], "R7 append");
    drive(0, 0, 0, 0, "R7 hold zero");

    // R3: clear with a simultaneous bit
    drive(0, 0, 1, 1, "R4 bit");
    drive(0, 1, 1, 1, "R3 clear priority");
    drive(0, 1, 1, 0, "R3 clear priority");

    // Random frames with idle gaps
    for (int p = 0; p < 40; p++) begin
      int len;
      len = 1 + ($urandom % 300);
      drive(0, 1, 0, 0, "R2 clear");
      for (int i = 0; i < len; i++) begin
        if (($urandom % 7) == 0) drive(0, 0, 0, $urandom % 2, "R5 gap");
        drive(0, 0, 1, $urandom % 2, "R4 R6 random bit");
      end
      drive(0, 0, 0, 0, "R5 hold");
      @(negedge clk);
      fin = crc_out;
      for (int i = 7; i >= 0; i--)
        drive(0, 0, 1, fin[i], "R7 append");
      drive(0, 0, 0, 0, "R7 zero");
      if (p == 20) drive(1, 0, 1, 1, "R1 mid reset");
    end

    drive(0, 0, 0, 0, "R5 final");
    repeat (3) @(negedge clk);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(PERIOD * 150000);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule